// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits beside a true dual-port memory whose two ports run on one clock. Each port presents an enable, a word address and a write request. When both ports are enabled on the same word, the block grants the port that got there first and drives an active-low busy line to the other. It also forms the write enable that the memory actually sees on each side, so a write from the losing side never reaches the array.

Arrival order is judged per cycle. A port counts as having arrived late when its enable or address differs from the value it held in the previous cycle. If both ports moved in the cycle where the collision begins, a parameter picks the winner. The grant is then held in a register until the collision ends, so it cannot change sides partway through.

A mode input selects between master and slave behaviour. In master mode the block arbitrates and drives busy. In slave mode it does no arbitration, its busy outputs stay inactive, and each port's busy input acts purely as a write blocker. Several slave copies can therefore follow one master when memories are placed side by side to widen the word.

Top module: `dp_busy_arbiter`

## Requirements
- R1: In master mode a busy output goes low only while both enables are 1 and the two addresses are equal. In every other case both busy outputs are 1.
- R2: The write-request inputs have no effect on which port is granted or on either busy output.
- R3: When a collision begins and only one port changed its enable or address since the previous cycle, that port is the later arrival and its busy output goes low in that same cycle.
- R4: The two busy outputs are never 0 together. When both ports changed in the cycle the collision begins, the parameter LEFT_WINS_TIE decides: 1 (default) grants the left port and marks the right busy, 0 does the opposite.
- R5: In master mode each write enable output equals enable AND write request AND that port's busy output. The busy inputs are ignored in this mode.
- R6: In slave mode (master_mode = 0) both busy outputs stay 1 whatever the addresses and enables.
- R7: In slave mode each write enable output equals enable AND write request AND that port's busy input. A busy input held at 1 gives normal writes. A busy input held at 0 blocks every write on that port.
- R8: While a collision continues from one cycle to the next in master mode, the busy port stays the same even if both ports then hold their inputs steady.
- R9: A busy output returns to 1 in the same cycle that the addresses stop matching or either port deselects. The stalled port's write then passes.
- R10: While rst_n is 0, both busy outputs are 1 and both write enables are 0. After release, each port's previous enable and address are taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = busy inputs only block writes |
| l_en | input | 1 | Left port enable |
| l_addr | input | AW | Left port word address |
| l_wr | input | 1 | Left port write request |
| l_busy_in_n | input | 1 | Left busy input, active low, used in slave mode |
| r_en | input | 1 | Right port enable |
| r_addr | input | AW | Right port word address |
| r_wr | input | 1 | Right port write request |
| r_busy_in_n | input | 1 | Right busy input, active low, used in slave mode |
| l_busy_n | output | 1 | Left busy indication, active low |
| r_busy_n | output | 1 | Right busy indication, active low |
| l_wr_en | output | 1 | Gated write enable to the memory's left port |
| r_wr_en | output | 1 | Gated write enable to the memory's right port |

## Verification
The internal state consists of each port's previous enable and address, plus the held winner. If the previous-value registers are wrong, the wrong side shows busy in the very cycle a collision starts. If the held winner is wrong, the grant flips on the next cycle of a steady collision, or busy lingers one cycle after the match ends. The stimulus therefore opens collisions from each side in turn, opens one with both ports moving together, holds collisions over several cycles and ends them both by address change and by deselect. Each result is compared in the cycle it appears. A memory model driven only by the gated write enables shows whether a blocked write reached the array.

// File: rtl/dpb_pkg.sv
`timescale 1ns/1ps
package dpb_pkg;
    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_L    = 2'd1,
        SIDE_R    = 2'd2
    } side_e;

    localparam int unsigned NPORT = 2;
    localparam int unsigned IDX_L = 0;
    localparam int unsigned IDX_R = 1;
endpackage

// File: rtl/dpb_port_track.sv
`timescale 1ns/1ps
// Remembers last cycle's enable and address of one port and flags a change.
module dpb_port_track #(
    parameter int unsigned AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic          moved
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en   = en;
        st_d.addr = addr;
        moved     = (en != st_q.en) || (addr != st_q.addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dpb_collision_arb.sv
`timescale 1ns/1ps
// Detects a same-word collision and decides which side loses.
module dpb_collision_arb
    import dpb_pkg::*;
#(
    parameter int unsigned AW            = 15,
    parameter bit          LEFT_WINS_TIE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_l,
    input  logic          en_r,
    input  logic [AW-1:0] addr_l,
    input  logic [AW-1:0] addr_r,
    input  logic          moved_l,
    input  logic          moved_r,
    output logic          lose_l,
    output logic          lose_r
);
    localparam side_e TIE_SIDE = LEFT_WINS_TIE ? SIDE_L : SIDE_R;

    typedef struct packed {
        side_e winner;
    } arb_t;

    arb_t  st_d, st_q;
    logic  match;
    side_e fresh;
    side_e cur;

    always_comb begin
        st_d  = st_q;
        match = en_l && en_r && (addr_l == addr_r);

        // The side that changed this cycle arrived later and loses.
        if (moved_l && !moved_r)      fresh = SIDE_R;
        else if (moved_r && !moved_l) fresh = SIDE_L;
        else                          fresh = TIE_SIDE;

        // A collision already in progress keeps its winner.
        cur = (st_q.winner != SIDE_NONE) ? st_q.winner : fresh;

        st_d.winner = match ? cur : SIDE_NONE;
        lose_l      = match && (cur == SIDE_R);
        lose_r      = match && (cur == SIDE_L);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{winner: SIDE_NONE};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dpb_write_gate.sv
`timescale 1ns/1ps
// Per-port busy driver and write gate; the mode picks the inhibit source.
module dpb_write_gate (
    input  logic rst_n,
    input  logic master_mode,
    input  logic en,
    input  logic wr,
    input  logic lose,
    input  logic busy_in_n,
    output logic busy_n,
    output logic wr_en
);
    logic inhibit;

    always_comb begin
        inhibit = master_mode ? lose : !busy_in_n;
        busy_n  = !(rst_n && master_mode && lose);
        wr_en   = rst_n && en && wr && !inhibit;
    end
endmodule

// File: rtl/dp_busy_arbiter.sv
`timescale 1ns/1ps
module dp_busy_arbiter
    import dpb_pkg::*;
#(
    parameter int unsigned AW            = 15,
    parameter bit          LEFT_WINS_TIE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_mode,
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    input  logic          l_wr,
    input  logic          l_busy_in_n,
    input  logic          r_en,
    input  logic [AW-1:0] r_addr,
    input  logic          r_wr,
    input  logic          r_busy_in_n,
    output logic          l_busy_n,
    output logic          r_busy_n,
    output logic          l_wr_en,
    output logic          r_wr_en
);
    logic          en_a     [NPORT];
    logic [AW-1:0] addr_a   [NPORT];
    logic          wr_a     [NPORT];
    logic          bin_a    [NPORT];
    logic          moved_a  [NPORT];
    logic          lose_a   [NPORT];
    logic          busy_a   [NPORT];
    logic          wen_a    [NPORT];

    always_comb begin
        en_a[IDX_L]   = l_en;        en_a[IDX_R]   = r_en;
        addr_a[IDX_L] = l_addr;      addr_a[IDX_R] = r_addr;
        wr_a[IDX_L]   = l_wr;        wr_a[IDX_R]   = r_wr;
        bin_a[IDX_L]  = l_busy_in_n; bin_a[IDX_R]  = r_busy_in_n;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpb_port_track #(.AW(AW)) i_track (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_a[p]),
            .addr  (addr_a[p]),
            .moved (moved_a[p])
        );

        dpb_write_gate i_gate (
            .rst_n       (rst_n),
            .master_mode (master_mode),
            .en          (en_a[p]),
            .wr          (wr_a[p]),
            .lose        (lose_a[p]),
            .busy_in_n   (bin_a[p]),
            .busy_n      (busy_a[p]),
            .wr_en       (wen_a[p])
        );
    end

    dpb_collision_arb #(.AW(AW), .LEFT_WINS_TIE(LEFT_WINS_TIE)) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_l    (l_en),
        .en_r    (r_en),
        .addr_l  (l_addr),
        .addr_r  (r_addr),
        .moved_l (moved_a[IDX_L]),
        .moved_r (moved_a[IDX_R]),
        .lose_l  (lose_a[IDX_L]),
        .lose_r  (lose_a[IDX_R])
    );

    assign l_busy_n = busy_a[IDX_L];
    assign r_busy_n = busy_a[IDX_R];
    assign l_wr_en  = wen_a[IDX_L];
    assign r_wr_en  = wen_a[IDX_R];
endmodule

// File: rtl/dpb_busy_checker.sv
`timescale 1ns/1ps
module dpb_busy_checker #(
    parameter int unsigned AW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          master_mode,
    input logic          l_en,
    input logic [AW-1:0] l_addr,
    input logic          l_wr,
    input logic          l_busy_in_n,
    input logic          r_en,
    input logic [AW-1:0] r_addr,
    input logic          r_wr,
    input logic          r_busy_in_n,
    input logic          l_busy_n,
    input logic          r_busy_n,
    input logic          l_wr_en,
    input logic          r_wr_en
);
    logic hit;
    assign hit = l_en && r_en && (l_addr == r_addr);

    AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy_n || r_busy_n); // R4

    AST_BUSY_L_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !l_busy_n |-> (hit && master_mode)); // R1

    AST_BUSY_R_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !r_busy_n |-> (hit && master_mode)); // R1

    AST_MASTER_GATES_L: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !l_busy_n) |-> !l_wr_en); // R5

    AST_MASTER_GATES_R: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !r_busy_n) |-> !r_wr_en); // R5

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy_n && r_busy_n)); // R6

    AST_SLAVE_BLOCK_L: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !l_busy_in_n) |-> !l_wr_en); // R7

    AST_SLAVE_BLOCK_R: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !r_busy_in_n) |-> !r_wr_en); // R7

    AST_GRANT_HELD_R: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && hit && $past(master_mode && hit && !r_busy_n)) |-> !r_busy_n); // R8

    AST_GRANT_HELD_L: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && hit && $past(master_mode && hit && !l_busy_n)) |-> !l_busy_n); // R8
endmodule

bind dp_busy_arbiter dpb_busy_checker #(.AW(AW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .l_en        (l_en),
    .l_addr      (l_addr),
    .l_wr        (l_wr),
    .l_busy_in_n (l_busy_in_n),
    .r_en        (r_en),
    .r_addr      (r_addr),
    .r_wr        (r_wr),
    .r_busy_in_n (r_busy_in_n),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_wr_en     (l_wr_en),
    .r_wr_en     (r_wr_en)
);

// File: tb/test_dp_busy_arbiter.sv
`timescale 1ns/1ps
module test_dp_busy_arbiter;
    localparam int unsigned AW = 4;
    localparam int unsigned NV = 18;

    typedef struct packed {
        logic       mm;
        logic       le;
        logic [3:0] la;
        logic       lw;
        logic       lb;
        logic       re;
        logic [3:0] ra;
        logic       rw;
        logic       rb;
        logic       x_lbn;
        logic       x_rbn;
        logic       x_lwe;
        logic       x_rwe;
        logic [3:0] req;
    } vec_t;

    // mm le la lw lb | re ra rw rb | lbn rbn lwe rwe | req
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,4'd3,1'b1,1'b1, 1'b0,4'd0,1'b0,1'b1, 1'b1,1'b1,1'b1,1'b0, 4'd1}, // 0  R1 one side off
        '{1'b1,1'b1,4'd3,1'b0,1'b1, 1'b1,4'd3,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd3}, // 1  R3 right arrives late
        '{1'b1,1'b1,4'd3,1'b1,1'b1, 1'b1,4'd3,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd5}, // 2  R5 R2 write gated
        '{1'b1,1'b1,4'd5,1'b1,1'b1, 1'b1,4'd3,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd9}, // 3  R9 mismatch release
        '{1'b1,1'b1,4'd3,1'b1,1'b1, 1'b1,4'd3,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1, 4'd3}, // 4  R3 left arrives late
        '{1'b1,1'b1,4'd3,1'b1,1'b1, 1'b1,4'd3,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1, 4'd8}, // 5  R8 held
        '{1'b1,1'b1,4'd3,1'b1,1'b1, 1'b0,4'd3,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0, 4'd9}, // 6  R9 deselect release
        '{1'b1,1'b1,4'd7,1'b1,1'b1, 1'b1,4'd7,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd4}, // 7  R4 tie, left wins
        '{1'b1,1'b1,4'd7,1'b1,1'b1, 1'b1,4'd7,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd8}, // 8  R8 held after tie
        '{1'b1,1'b0,4'd7,1'b0,1'b1, 1'b0,4'd7,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0, 4'd1}, // 9  R1 both off
        '{1'b1,1'b1,4'd2,1'b0,1'b1, 1'b0,4'd0,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0, 4'd1}, // 10 R1
        '{1'b1,1'b1,4'd2,1'b0,1'b1, 1'b1,4'd2,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd3}, // 11 R3
        '{1'b0,1'b1,4'd1,1'b1,1'b1, 1'b1,4'd1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd6}, // 12 R6 slave no arbitration
        '{1'b0,1'b1,4'd1,1'b1,1'b0, 1'b1,4'd1,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b1, 4'd7}, // 13 R7 left blocked
        '{1'b0,1'b1,4'd1,1'b1,1'b0, 1'b1,4'd2,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd7}, // 14 R7 both blocked
        '{1'b1,1'b1,4'd9,1'b1,1'b0, 1'b0,4'd0,1'b0,1'b1, 1'b1,1'b1,1'b1,1'b0, 4'd5}, // 15 R5 busy_in ignored
        '{1'b1,1'b1,4'd9,1'b1,1'b0, 1'b1,4'd9,1'b1,1'b0, 1'b1,1'b0,1'b1,1'b0, 4'd5}, // 16 R5
        '{1'b1,1'b1,4'd9,1'b0,1'b0, 1'b1,4'd9,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd2}  // 17 R2 writes dropped, grant kept
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          master_mode;
    logic          l_en, r_en, l_wr, r_wr, l_busy_in_n, r_busy_in_n;
    logic [AW-1:0] l_addr, r_addr;
    logic          l_busy_n, r_busy_n, l_wr_en, r_wr_en;
    logic          a_lbn, a_rbn, a_lwe, a_rwe;
    logic [1:0]    mem [1<<AW];
    int            tests = 0;
    int            fails = 0;
    bit            done  = 1'b0;

    always #4 clk = ~clk;

    dp_busy_arbiter #(.AW(AW), .LEFT_WINS_TIE(1'b1)) i_dp_busy_arbiter (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr), .l_busy_in_n(l_busy_in_n),
        .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
    );

    dp_busy_arbiter #(.AW(AW), .LEFT_WINS_TIE(1'b0)) i_alt (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr), .l_busy_in_n(l_busy_in_n),
        .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(a_lbn), .r_busy_n(a_rbn), .l_wr_en(a_lwe), .r_wr_en(a_rwe)
    );

    // Memory model written only through the gated enables (1 = left, 2 = right).
    always @(posedge clk) begin
        if (l_wr_en) mem[l_addr] <= 2'd1;
        if (r_wr_en) mem[r_addr] <= 2'd2;
    end

    // R5: a write must never leave a side that shows busy.
    always @(posedge clk) begin
        if (rst_n && ((l_wr_en && !l_busy_n) || (r_wr_en && !r_busy_n))) begin
            tests++; fails++;
            $display("FAIL R5 write from busy side: lwe=%b lbn=%b rwe=%b rbn=%b expected no write",
                     l_wr_en, l_busy_n, r_wr_en, r_busy_n);
        end
    end

    task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s {lbn,rbn,lwe,rwe} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        master_mode = v.mm;
        l_en = v.le; l_addr = v.la; l_wr = v.lw; l_busy_in_n = v.lb;
        r_en = v.re; r_addr = v.ra; r_wr = v.rw; r_busy_in_n = v.rb;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < (1 << AW); a++) mem[a] = 2'd0;
        rst_n = 1'b0;
        drive('0);
        repeat (3) @(negedge clk);
        #2;
        check4("R10 reset idle", {l_busy_n, r_busy_n, l_wr_en, r_wr_en}, 4'b1100);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #2;
            check4($sformatf("R%0d vector %0d", VEC[i].req, i),
                   {l_busy_n, r_busy_n, l_wr_en, r_wr_en},
                   {VEC[i].x_lbn, VEC[i].x_rbn, VEC[i].x_lwe, VEC[i].x_rwe});
            if (i == 7)
                check4("R4 tie with right priority", {a_lbn, a_rbn, a_lwe, a_rwe}, 4'b0101);
            if (i == 9) begin
                tests++;
                if (mem[7] !== 2'd1) begin
                    fails++;
                    $display("FAIL R5 word 7 writer actual=%0d expected=1", mem[7]);
                end
            end
        end

        // R10: reset during a collision with writes pending.
        @(negedge clk);
        drive('{1'b1,1'b1,4'd4,1'b1,1'b1, 1'b1,4'd4,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd10});
        rst_n = 1'b0;
        #2;
        check4("R10 reset mid-collision", {l_busy_n, r_busy_n, l_wr_en, r_wr_en}, 4'b1100);
        // R4: after release both ports look moved, so the tie rule applies.
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check4("R4 tie after reset", {l_busy_n, r_busy_n, l_wr_en, r_wr_en}, 4'b1010);
        check4("R4 tie after reset, right priority", {a_lbn, a_rbn, a_lwe, a_rwe}, 4'b0101);
        // R8: hold steady one more cycle.
        @(negedge clk);
        #2;
        check4("R8 held after reset tie", {l_busy_n, r_busy_n, l_wr_en, r_wr_en}, 4'b1010);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule